// File: doc/BRIEF.md
# Signature-Based Chunk Conflict Detector

This block watches a group of processors that each run their code as atomic chunks. For every processor it keeps two compact address summaries of the chunk in flight, one for lines read and one for lines written. Each summary is a Bloom filter: every access sets one bit in each of several banks, and each bank uses its own hash of the cache-line address. No data leaves a processor while its chunk runs. When a processor wants to commit, it raises a request. An arbiter grants one committer per cycle. In the following cycle the committer's write summary goes out on a broadcast bus, and that summary is the only thing sent.

In the broadcast cycle, every other active chunk intersects the broadcast write summary with its own read summary. If they overlap, that chunk may have read stale data, so its squash output rises for one cycle. The committing chunk always goes ahead. Conflicts are checked only at commit time and never on individual accesses. The hashing can report a conflict that did not really happen (a false positive). It never misses a line that both chunks touched.

After a commit or a squash, the processor's chunk becomes inactive and both of its summaries are empty from the next cycle on. A new chunk starts only with an explicit begin pulse. The block stores no data and does not restart squashed code.

Top module: `sig_conflict_detector`

## Requirements
- R1: An access by an active chunk sets one bit in each of the 4 banks of its read or write summary. The line is addr[31:6]. For bank b, the 128-bit field sits at summary bits [128b+127:128b], and the bit index is the XOR of the 7-bit slices of (line >> b), zero-padded to 28 bits.
- R2: A begin pulse empties both summaries and makes the chunk active from the next cycle on. Accesses made while a chunk is inactive are not recorded.
- R3: At most one grant is issued per cycle, in the same cycle as the request, and only to an active requester that is not being squashed. The arbiter is round-robin. After reset, processor 0 has first priority. After each grant, first priority moves to the processor one index above the winner, wrapping around.
- R4: The cycle after a grant, the broadcast valid output is high for exactly one cycle. The broadcast summary then equals the winner's write summary as it stood at the start of the grant cycle. Stores made during the grant cycle are not part of it.
- R5: In the broadcast cycle, an active processor other than the committer asserts squash if every bank of its read summary shares at least one set bit with the broadcast summary. If the two chunks overlap only in writes, there is no squash, and a committer is never squashed by its own broadcast.
- R6: A load and a store to the same 64-byte line always produce a squash.
- R7: A processor squashed in the same cycle as its commit request receives no grant.
- R8: After a commit or a squash, the chunk is inactive: its requests are ignored, and both of its summaries are empty from the next cycle.
- R9: After reset, all grants, all squashes and the broadcast valid output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| begin_i | input | NPROC | Start a new chunk, one bit per processor |
| ld_valid_i | input | NPROC | Load issued this cycle |
| ld_addr_i | input | NPROC x 32 | Load byte address |
| st_valid_i | input | NPROC | Store issued this cycle |
| st_addr_i | input | NPROC x 32 | Store byte address |
| commit_req_i | input | NPROC | Commit request |
| commit_gnt_o | output | NPROC | Commit grant, at most one bit high |
| bcast_valid_o | output | 1 | Broadcast summary is valid |
| bcast_sig_o | output | 512 | Broadcast write summary of the last committer |
| squash_o | output | NPROC | Squash pulse to a conflicting chunk |

## Verification
The squash caused by one processor's broadcast and the grant decision for another processor's commit request fall in the same cycle. The bench provokes this by having a reader request commit in exactly the cycle when the writer's broadcast hits its read summary. At that point round-robin priority already favours the reader. The bench then requires a squash with no grant, and one cycle later requires that the reader's request is ignored. An address sweep also sets every hash-predicted squash against the design's output, including same-line and same-address pairs that must always conflict.

// File: rtl/sigcd_pkg.sv
package sigcd_pkg;

    localparam int ADDR_W    = 32;
    localparam int LINE_OFF  = 6;
    localparam int NBANK     = 4;
    localparam int BANK_BITS = 128;
    localparam int IDX_W     = $clog2(BANK_BITS);
    localparam int SIG_W     = NBANK * BANK_BITS;
    localparam int LINE_W    = ADDR_W - LINE_OFF;
    localparam int NSLICE    = (LINE_W + IDX_W - 1) / IDX_W;

    typedef logic [NBANK-1:0][BANK_BITS-1:0] sig_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } acc_t;

    function automatic logic [IDX_W-1:0] bank_hash(logic [ADDR_W-1:0] addr, int bank);
        logic [LINE_W-1:0]        line;
        logic [NSLICE*IDX_W-1:0]  pad;
        logic [IDX_W-1:0]         idx;
        line = addr[ADDR_W-1:LINE_OFF];
        pad  = '0;
        pad[LINE_W-1:0] = line >> bank;
        idx  = '0;
        for (int k = 0; k < NSLICE; k++) begin
            idx = idx ^ pad[k*IDX_W +: IDX_W];
        end
        return idx;
    endfunction

    function automatic sig_t sig_of(logic [ADDR_W-1:0] addr);
        sig_t s;
        s = '0;
        for (int b = 0; b < NBANK; b++) begin
            s[b][bank_hash(addr, b)] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic sig_meet(sig_t x, sig_t y);
        logic all_hit;
        all_hit = 1'b1;
        for (int b = 0; b < NBANK; b++) begin
            if ((x[b] & y[b]) == '0) all_hit = 1'b0;
        end
        return all_hit;
    endfunction

endpackage

// File: rtl/sigcd_sigunit.sv
module sigcd_sigunit
    import sigcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic active_i,
    input  acc_t ld_i,
    input  acc_t st_i,
    input  sig_t bcast_i,
    output sig_t wsig_o,
    output logic hit_o
);

    sig_t rsig_q;
    sig_t wsig_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            rsig_q <= '0;
            wsig_q <= '0;
        end else begin
            if (active_i && ld_i.valid) rsig_q <= rsig_q | sig_of(ld_i.addr);
            if (active_i && st_i.valid) wsig_q <= wsig_q | sig_of(st_i.addr);
        end
    end

    assign wsig_o = wsig_q;
    assign hit_o  = sig_meet(rsig_q, bcast_i);

endmodule

// File: rtl/sigcd_rr_arb.sv
module sigcd_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] elig_i,
    output logic [N-1:0] gnt_o
);

    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] win;
    logic             found;
    int               idx;

    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        win   = '0;
        idx   = 0;
        for (int off = 0; off < N; off++) begin
            idx = int'(ptr_q) + off;
            if (idx >= N) idx = idx - N;
            if (!found && elig_i[idx]) begin
                found      = 1'b1;
                gnt_o[idx] = 1'b1;
                win        = PTR_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
        end
    end

endmodule

// File: rtl/sig_conflict_detector.sv
module sig_conflict_detector
    import sigcd_pkg::*;
#(
    parameter int NPROC = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NPROC-1:0]               begin_i,
    input  logic [NPROC-1:0]               ld_valid_i,
    input  logic [NPROC-1:0][ADDR_W-1:0]   ld_addr_i,
    input  logic [NPROC-1:0]               st_valid_i,
    input  logic [NPROC-1:0][ADDR_W-1:0]   st_addr_i,
    input  logic [NPROC-1:0]               commit_req_i,
    output logic [NPROC-1:0]               commit_gnt_o,
    output logic                           bcast_valid_o,
    output logic [SIG_W-1:0]               bcast_sig_o,
    output logic [NPROC-1:0]               squash_o
);

    logic [NPROC-1:0] active_q;
    logic [NPROC-1:0] hit;
    logic [NPROC-1:0] elig;
    sig_t             wsig [NPROC];
    sig_t             sel_sig;
    sig_t             bcast_q;
    logic             bvalid_q;

    for (genvar p = 0; p < NPROC; p++) begin : g_unit
        acc_t ld_a;
        acc_t st_a;
        assign ld_a = '{valid: ld_valid_i[p], addr: ld_addr_i[p]};
        assign st_a = '{valid: st_valid_i[p], addr: st_addr_i[p]};
        sigcd_sigunit u_sig (
            .clk      (clk),
            .rst      (rst),
            .clear_i  (begin_i[p] | commit_gnt_o[p] | squash_o[p]),
            .active_i (active_q[p]),
            .ld_i     (ld_a),
            .st_i     (st_a),
            .bcast_i  (bcast_q),
            .wsig_o   (wsig[p]),
            .hit_o    (hit[p])
        );
    end

    assign squash_o = {NPROC{bvalid_q}} & active_q & hit;
    assign elig     = commit_req_i & active_q & ~squash_o;

    sigcd_rr_arb #(.N(NPROC)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .elig_i (elig),
        .gnt_o  (commit_gnt_o)
    );

    always_comb begin
        sel_sig = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (commit_gnt_o[p]) sel_sig = sel_sig | wsig[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            bvalid_q <= 1'b0;
            bcast_q  <= '0;
        end else begin
            active_q <= begin_i | (active_q & ~commit_gnt_o & ~squash_o);
            bvalid_q <= |commit_gnt_o;
            bcast_q  <= sel_sig;
        end
    end

    assign bcast_valid_o = bvalid_q;
    assign bcast_sig_o   = bcast_q;

endmodule

// File: rtl/sigcd_checker.sv
module sigcd_checker #(
    parameter int NPROC = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NPROC-1:0] req,
    input logic [NPROC-1:0] gnt,
    input logic [NPROC-1:0] squash,
    input logic             bvalid
);

    assert_gnt_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_gnt_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    assert_bcast_after_gnt_R4: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |=> bvalid);

    assert_no_bcast_without_gnt_R4: assert property (@(posedge clk) disable iff (rst)
        !(|gnt) |=> !bvalid);

    assert_squash_needs_bcast_R5: assert property (@(posedge clk) disable iff (rst)
        (|squash) |-> bvalid);

    assert_no_self_squash_R5: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |=> ((squash & $past(gnt)) == '0));

    assert_squash_loses_gnt_R7: assert property (@(posedge clk) disable iff (rst)
        (gnt & squash) == '0);

    assert_squash_once_R8: assert property (@(posedge clk) disable iff (rst)
        (|squash) |=> ((squash & $past(squash)) == '0));

endmodule

bind sig_conflict_detector sigcd_checker #(.NPROC(NPROC)) u_sigcd_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (commit_req_i),
    .gnt    (commit_gnt_o),
    .squash (squash_o),
    .bvalid (bcast_valid_o)
);

// File: tb/sig_conflict_detector_bench.sv
module sig_conflict_detector_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int AW  = 32;
    localparam int SW  = 512;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NP-1:0]          begin_r, ld_v, st_v, req;
    logic [NP-1:0][AW-1:0]  ld_a, st_a;
    logic [NP-1:0]          gnt, squash;
    logic                   bvalid;
    logic [SW-1:0]          bsig;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_conflict_detector #(.NPROC(NP)) u_sig_conflict_detector (
        .clk(clk), .rst(rst), .begin_i(begin_r),
        .ld_valid_i(ld_v), .ld_addr_i(ld_a),
        .st_valid_i(st_v), .st_addr_i(st_a),
        .commit_req_i(req), .commit_gnt_o(gnt),
        .bcast_valid_o(bvalid), .bcast_sig_o(bsig), .squash_o(squash)
    );

    // Hash as stated in R1, computed bit by bit.
    function automatic logic [SW-1:0] model_sig(logic [AW-1:0] addr);
        logic [SW-1:0] s;
        logic [25:0]   line;
        int            pos;
        logic [6:0]    ix;
        s = '0;
        line = addr[31:6];
        for (int b = 0; b < 4; b++) begin
            ix = '0;
            for (int j = 0; j < 7; j++) begin
                for (int k = 0; k < 4; k++) begin
                    pos = b + k*7 + j;
                    if (pos < 26) ix[j] = ix[j] ^ line[pos];
                end
            end
            s[b*128 + int'(ix)] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic model_meet(logic [SW-1:0] x, logic [SW-1:0] y);
        logic r;
        r = 1'b1;
        for (int b = 0; b < 4; b++) begin
            if ((x[b*128 +: 128] & y[b*128 +: 128]) == '0) r = 1'b0;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        begin_r = '0; ld_v = '0; st_v = '0; req = '0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] x, a, b, c;
        logic        exp_hit;
        begin_r = '0; ld_v = '0; st_v = '0; req = '0; ld_a = '0; st_a = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        tick(); req = 4'b1111; settle();
        chk("R9 grant after reset", SW'(gnt), '0);
        chk("R9 squash after reset", SW'(squash), '0);
        chk("R9 bcast valid after reset", SW'(bvalid), '0);

        // R3 round-robin from processor 0; R8 inactive requests ignored
        tick(); begin_r = 4'b1111;
        tick(); req = 4'b1111; settle(); chk("R3 rr first", SW'(gnt), SW'(4'b0001));
        tick(); req = 4'b1111; settle(); chk("R3 rr second", SW'(gnt), SW'(4'b0010));
        chk("R4 empty bcast", bsig, '0);
        tick(); req = 4'b1111; settle(); chk("R3 rr third", SW'(gnt), SW'(4'b0100));
        tick(); req = 4'b1111; settle(); chk("R3 rr fourth", SW'(gnt), SW'(4'b1000));
        tick(); req = 4'b1111; settle(); chk("R8 inactive req ignored", SW'(gnt), '0);
        chk("R4 bcast after last grant", SW'(bvalid), 1);
        tick(); settle(); chk("R4 bcast one cycle", SW'(bvalid), 0);
        tick(); begin_r = 4'b1111;
        tick(); req = 4'b1010; settle(); chk("R3 rr wrap to 1", SW'(gnt), SW'(4'b0010));
        tick(); req = 4'b1010; settle(); chk("R3 rr next 3", SW'(gnt), SW'(4'b1000));
        tick(); req = 4'b1111; settle(); chk("R3 rr wrap to 0", SW'(gnt), SW'(4'b0001));
        tick(); req = 4'b1111; settle(); chk("R3 rr then 2", SW'(gnt), SW'(4'b0100));
        tick(); tick();

        // R7 squash in the request cycle loses the grant (priority points at 3, then 1)
        a = 32'h1234_5680;
        tick(); begin_r = 4'b0011;
        tick(); st_v[0] = 1; st_a[0] = a; ld_v[1] = 1; ld_a[1] = a;
        tick(); req = 4'b0011; settle(); chk("R3 grant to 0", SW'(gnt), SW'(4'b0001));
        tick(); req = 4'b0010; settle();
        chk("R7 squash of requester", SW'(squash), SW'(4'b0010));
        chk("R7 no grant when squashed", SW'(gnt), '0);
        chk("R4 bcast sig", bsig, model_sig(a));
        tick(); req = 4'b0010; settle();
        chk("R8 squashed req ignored", SW'(gnt), '0);
        chk("R8 squash single pulse", SW'(squash), '0);

        // R8 summaries cleared after commit and after squash
        tick(); begin_r = 4'b0011;
        tick(); req = 4'b0001; settle(); chk("R3 grant 0 again", SW'(gnt), SW'(4'b0001));
        tick(); settle(); chk("R8 write summary cleared", bsig, '0);
        chk("R8 bcast valid", SW'(bvalid), 1);
        tick(); begin_r = 4'b0001;
        tick(); st_v[0] = 1; st_a[0] = a;
        tick(); req = 4'b0001;
        tick(); settle(); chk("R8 read summary cleared", SW'(squash), '0);

        // R2 inactive loads not recorded; R4 grant-cycle store excluded
        c = 32'h00AB_C000;
        tick(); ld_v[2] = 1; ld_a[2] = a;
        tick(); begin_r = 4'b0101;
        tick(); st_v[0] = 1; st_a[0] = a;
        tick(); req = 4'b0001; st_v[0] = 1; st_a[0] = c;
        tick(); settle();
        chk("R2 inactive load not recorded", SW'(squash), '0);
        chk("R4 grant-cycle store excluded", bsig, model_sig(a));

        // R5 write-write overlap and own load give no squash; R1 multiple stores
        b = 32'h0F0F_0040;
        tick(); begin_r = 4'b0011;
        tick(); st_v[0] = 1; st_a[0] = a; ld_v[0] = 1; ld_a[0] = a; st_v[1] = 1; st_a[1] = a;
        tick(); st_v[0] = 1; st_a[0] = b;
        tick(); req = 4'b0001; settle(); chk("R3 grant 0 write-write", SW'(gnt), SW'(4'b0001));
        tick(); settle();
        chk("R5 write-write no squash", SW'(squash), '0);
        chk("R1 union of stores", bsig, model_sig(a) | model_sig(b));

        // R1 R5 R6 address sweep
        x = 32'hACE1_2345;
        for (int i = 0; i < 256; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            a = x;
            case (i % 4)
                0: b = a;
                1: b = a ^ 32'(i % 64);
                2: b = a + 32'(64 * (1 + i % 7));
                default: begin x = x * 32'd1103515245 + 32'd12345; b = x; end
            endcase
            exp_hit = model_meet(model_sig(a), model_sig(b));
            tick(); begin_r = 4'b0011;
            tick(); st_v[0] = 1; st_a[0] = a; ld_v[1] = 1; ld_a[1] = b;
            tick(); req = 4'b0001; settle();
            chk("R3 sweep grant", SW'(gnt), SW'(4'b0001));
            tick(); settle();
            chk("R1 sweep bcast sig", bsig, model_sig(a));
            chk("R5 sweep squash", SW'(squash), SW'({2'b00, exp_hit, 1'b0}));
            if (i % 4 < 2) chk("R6 same line conflicts", SW'(squash[1]), 1);
        end

        report();
    end

endmodule